// File: doc/BRIEF.md
# Octal DAC Register Bank Controller

This block sits behind a serial receiver in a multi-channel converter. It takes complete 32-bit command words, one per `frame_valid` pulse, and keeps two registers for each of eight channels. The first is an input (staging) register and the second is the DAC register that drives the converter core. Commands can stage a code, copy staged codes to the DAC registers, or write and update in a single step. Each command addresses one channel or all of them. Other commands load a clear-code selector, a load-override mask and a reference-enable flag, reset the bank to its power-on code, or pass a power-down request on to the analog side.

The active-low load level `load_n` copies every input register into its DAC register while it is low. A channel whose override-mask bit is set skips the wait for the load level and updates each time its input register is written. The active-low `clear_n` level forces every register to the selected clear code. All effects are registered: a frame presented in cycle t shows at the outputs after the next rising clock edge.

Top module: `octal_dac_regbank`

## Requirements
- R1: In a frame word, bits 27:24 hold the command, bits 23:20 hold the address and bits 19:4 hold the 16-bit code. Bits 31:28 and 3:0 have no effect on the result.
- R2: Address values 0 to 7 select channels A to H. Channel k appears on `dac_code[16k+15:16k]`. Address 4'hF selects all channels. Addresses 8 to 14 select no channel.
- R3: Command 4'h0 writes the addressed input registers only. A DAC register with mask bit 0 keeps its value while `load_n` is high.
- R4: Command 4'h1 copies each addressed input register into its DAC register.
- R5: Command 4'h2 writes the addressed input registers and then copies every input register into its DAC register.
- R6: Command 4'h3 writes the addressed input registers and updates their DAC registers in the same cycle.
- R7: While `load_n` is low, every DAC register takes its input register's value. A write that arrives in the same cycle reaches the DAC register in that cycle.
- R8: Command 4'h6 loads the override mask from frame bits 7:0, with bit k for channel k. A channel whose mask bit is 1 updates its DAC register whenever its input register is written. No other command changes the mask, except a reset.
- R9: Command 4'h5 loads the clear selector from frame bits 1:0: 00 selects 16'h0000, 01 selects 16'h8000 and 10 selects 16'hFFFF. The value 11 keeps the current selection. While `clear_n` is low, all input and DAC registers load the selected code, and a frame in the same cycle is discarded.
- R10: Command 4'h7 and hardware reset both load the power-on code into all registers, clear the mask, set the selector to 00, turn the reference off and raise `por_flag`. The power-on code is 16'h8000 when POR_MIDSCALE=1 and 0 otherwise. `por_flag` falls on the next accepted frame that carries a non-reserved command other than 4'h7.
- R11: Command 4'h8 sets `ref_on` to frame bit 0.
- R12: Command 4'h4 raises `pd_strobe` for one cycle, with `pd_arg` equal to frame bits 9:0. It changes no channel register.
- R13: Commands 4'h9 to 4'hF change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_valid | input | 1 | One-cycle strobe marking a complete frame |
| frame_word | input | 32 | Frame contents |
| load_n | input | 1 | Synchronised active-low load level |
| clear_n | input | 1 | Active-low clear level |
| dac_code | output | 128 | Eight DAC register values, channel A in the low 16 bits |
| por_flag | output | 1 | High from a reset until the first effective write |
| ref_on | output | 1 | Reference-enable flag |
| pd_strobe | output | 1 | One-cycle power-down request |
| pd_arg | output | 10 | Power-down argument, frame bits 9:0 |

## Verification
The bench builds the bank with the default eight channels of 16 bits and with POR_MIDSCALE set to 1. This makes the power-on code 16'h8000, which differs from the reset value of the clear selector (zero). A software reset can therefore be told apart from a clear pulse, and a stale power-on value can be told apart from a fresh write. The bench fills the unused frame fields with non-zero patterns, so a misplaced field slice shows up as a wrong code.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef enum logic [3:0] {
    OP_STAGE       = 4'h0,
    OP_COMMIT      = 4'h1,
    OP_STAGE_ALL   = 4'h2,
    OP_STAGE_COMMIT= 4'h3,
    OP_PWRDN       = 4'h4,
    OP_CLR_SEL     = 4'h5,
    OP_BYPASS_MASK = 4'h6,
    OP_SOFT_RST    = 4'h7,
    OP_REF         = 4'h8
  } dac_op_e;

  typedef enum logic [1:0] {
    CSEL_ZERO = 2'b00,
    CSEL_MID  = 2'b01,
    CSEL_FULL = 2'b10,
    CSEL_KEEP = 2'b11
  } clr_sel_e;

  // one-hot action decoded from an accepted frame
  typedef struct packed {
    logic stage;
    logic commit;
    logic stage_all;
    logic stage_commit;
    logic pwrdn;
    logic clr_sel;
    logic mask_ld;
    logic soft_rst;
    logic ref_set;
  } dac_act_t;

endpackage

// File: rtl/dac_frame_decode.sv
module dac_frame_decode
  import dacbank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 16
) (
  input  logic              frame_valid,
  input  logic [31:0]       frame_word,
  input  logic              clear_n,
  output dac_act_t          act,
  output logic [NUM_CH-1:0] ch_hit,
  output logic [CODE_W-1:0] wr_code
);

  logic [3:0] op_field;
  logic [3:0] addr_field;
  logic       accept;

  assign op_field   = frame_word[27:24];
  assign addr_field = frame_word[23:20];
  // clear has priority: a frame that meets a clear is dropped
  assign accept     = frame_valid && clear_n;
  // code is MSB-aligned at bit 19
  assign wr_code    = frame_word[19 -: CODE_W];

  always_comb begin
    act = '0;
    if (accept) begin
      case (op_field)
        OP_STAGE:        act.stage        = 1'b1;
        OP_COMMIT:       act.commit       = 1'b1;
        OP_STAGE_ALL:    act.stage_all    = 1'b1;
        OP_STAGE_COMMIT: act.stage_commit = 1'b1;
        OP_PWRDN:        act.pwrdn        = 1'b1;
        OP_CLR_SEL:      act.clr_sel      = 1'b1;
        OP_BYPASS_MASK:  act.mask_ld      = 1'b1;
        OP_SOFT_RST:     act.soft_rst     = 1'b1;
        OP_REF:          act.ref_set      = 1'b1;
        default:         act              = '0;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_hit
    assign ch_hit[k] = (addr_field == 4'(k)) || (addr_field == ADDR_ALL);
  end

  logic unused_frame_bits;
  assign unused_frame_bits = ^{frame_word[31:28], frame_word[19-CODE_W:0]};

endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int              CODE_W   = 16,
  parameter logic [CODE_W-1:0] POR_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_n,
  input  logic [CODE_W-1:0] clr_code,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              upd_en,
  input  logic              bypass,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_q
);

  logic [CODE_W-1:0] in_q, in_d, dac_d;
  logic              in_en, dac_en;

  always_comb begin
    in_en  = 1'b0;
    in_d   = in_q;
    dac_en = 1'b0;
    dac_d  = dac_q;
    if (!clear_n) begin
      in_en  = 1'b1;
      in_d   = clr_code;
      dac_en = 1'b1;
      dac_d  = clr_code;
    end else if (soft_rst) begin
      in_en  = 1'b1;
      in_d   = POR_CODE;
      dac_en = 1'b1;
      dac_d  = POR_CODE;
    end else begin
      if (wr_en) begin
        in_en = 1'b1;
        in_d  = wr_code;
      end
      // forward the fresh staged value: write lands before the update
      if (!load_n || upd_en || (wr_en && bypass)) begin
        dac_en = 1'b1;
        dac_d  = in_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= POR_CODE;
      dac_q <= POR_CODE;
    end else begin
      if (in_en)  in_q  <= in_d;
      if (dac_en) dac_q <= dac_d;
    end
  end

  assert_clear_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (in_q == $past(clr_code) && dac_q == $past(clr_code)));

  assert_strobe_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (dac_q == in_q));

endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dacbank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dac_act_t          act,
  input  logic [9:0]        arg,
  output logic [NUM_CH-1:0] mask_q,
  output logic [CODE_W-1:0] clr_code,
  output logic              ref_on,
  output logic              por_flag,
  output logic              pd_strobe,
  output logic [9:0]        pd_arg
);

  localparam logic [CODE_W-1:0] CODE_MID  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_FULL = '1;

  logic [NUM_CH-1:0] mask_d;
  logic [1:0]        csel_q, csel_d;
  logic              ref_d, por_d, pd_d;
  logic              any_act;

  assign any_act = |act;

  always_comb begin
    mask_d = mask_q;
    csel_d = csel_q;
    ref_d  = ref_on;
    por_d  = por_flag;
    pd_d   = act.pwrdn;
    if (act.soft_rst) begin
      mask_d = '0;
      csel_d = CSEL_ZERO;
      ref_d  = 1'b0;
      por_d  = 1'b1;
    end else begin
      if (any_act)                            por_d  = 1'b0;
      if (act.mask_ld)                        mask_d = arg[NUM_CH-1:0];
      if (act.clr_sel && arg[1:0] != CSEL_KEEP) csel_d = arg[1:0];
      if (act.ref_set)                        ref_d  = arg[0];
    end
  end

  always_comb begin
    case (csel_q)
      CSEL_MID:  clr_code = CODE_MID;
      CSEL_FULL: clr_code = CODE_FULL;
      default:   clr_code = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      csel_q    <= CSEL_ZERO;
      ref_on    <= 1'b0;
      por_flag  <= 1'b1;
      pd_strobe <= 1'b0;
      pd_arg    <= '0;
    end else begin
      mask_q    <= mask_d;
      csel_q    <= csel_d;
      ref_on    <= ref_d;
      por_flag  <= por_d;
      pd_strobe <= pd_d;
      if (act.pwrdn) pd_arg <= arg;
    end
  end

  assert_keep_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act.clr_sel && arg[1:0] == 2'b11) |=> $stable(csel_q));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!act.mask_ld && !act.soft_rst) |=> $stable(mask_q));

  assert_soft_rst_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act.soft_rst |=> (!ref_on && mask_q == '0 && clr_code == '0 && por_flag));

endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dacbank_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int CODE_W       = 16,
  parameter bit POR_MIDSCALE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_valid,
  input  logic [31:0]              frame_word,
  input  logic                     load_n,
  input  logic                     clear_n,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic                     por_flag,
  output logic                     ref_on,
  output logic                     pd_strobe,
  output logic [9:0]               pd_arg
);

  localparam logic [CODE_W-1:0] POR_CODE =
    POR_MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  dac_act_t          act;
  logic [NUM_CH-1:0] ch_hit;
  logic [CODE_W-1:0] wr_code;
  logic [NUM_CH-1:0] mask_q;
  logic [CODE_W-1:0] clr_code;

  dac_frame_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .clear_n     (clear_n),
    .act         (act),
    .ch_hit      (ch_hit),
    .wr_code     (wr_code)
  );

  dac_ctrl_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .act       (act),
    .arg       (frame_word[9:0]),
    .mask_q    (mask_q),
    .clr_code  (clr_code),
    .ref_on    (ref_on),
    .por_flag  (por_flag),
    .pd_strobe (pd_strobe),
    .pd_arg    (pd_arg)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic ch_wr, ch_upd;
    assign ch_wr  = (act.stage || act.stage_all || act.stage_commit) && ch_hit[k];
    assign ch_upd = ((act.commit || act.stage_commit) && ch_hit[k]) || act.stage_all;

    dac_chan #(.CODE_W(CODE_W), .POR_CODE(POR_CODE)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .clear_n  (clear_n),
      .clr_code (clr_code),
      .soft_rst (act.soft_rst),
      .wr_en    (ch_wr),
      .wr_code  (wr_code),
      .upd_en   (ch_upd),
      .bypass   (mask_q[k]),
      .load_n   (load_n),
      .dac_q    (dac_code[k*CODE_W +: CODE_W])
    );
  end

  assert_reserved_inert_R13: assert property (@(posedge clk) disable iff (!rst_n_s)
    (frame_valid && frame_word[27:24] > 4'h8) |-> (act == '0));

  assert_pwrdn_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pd_strobe && $past(load_n)) |-> $stable(dac_code));

endmodule

// File: tb/octal_dac_regbank_test.sv
module octal_dac_regbank_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         frame_valid;
  logic [31:0]  frame_word;
  logic         load_n;
  logic         clear_n;
  logic [127:0] dac_code;
  logic         por_flag, ref_on, pd_strobe;
  logic [9:0]   pd_arg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  octal_dac_regbank #(.NUM_CH(8), .CODE_W(16), .POR_MIDSCALE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
    .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code), .por_flag(por_flag),
    .ref_on(ref_on), .pd_strobe(pd_strobe), .pd_arg(pd_arg)
  );

  typedef struct packed {
    logic [31:0] w;
    logic        ld;
    logic [3:0]  ch;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // junk nibbles 4'hA (bits 31:28) and 4'h5 (bits 3:0) exercise R1
  localparam vec_t VT [15] = '{
    '{32'hA021_2345, 1'b1, 4'd2, 16'h8000, 4'd3},  // R3 stage only
    '{32'hA120_0005, 1'b1, 4'd2, 16'h1234, 4'd4},  // R4 commit
    '{32'hA05A_BCD5, 1'b1, 4'd5, 16'h8000, 4'd3},  // R3
    '{32'hA300_F0F5, 1'b1, 4'd0, 16'h0F0F, 4'd6},  // R6 stage+commit
    '{32'hA277_7775, 1'b1, 4'd5, 16'hABCD, 4'd5},  // R5 update all
    '{32'hA970_0005, 1'b1, 4'd7, 16'h7777, 4'd13}, // R13 reserved, R5 result
    '{32'hA011_1115, 1'b0, 4'd1, 16'h1111, 4'd7},  // R7 load low
    '{32'hA0F2_2225, 1'b1, 4'd3, 16'h8000, 4'd2},  // R2 broadcast stage
    '{32'hA1F0_0005, 1'b1, 4'd6, 16'h2222, 4'd2},  // R2 broadcast commit
    '{32'hA09D_EAD5, 1'b1, 4'd4, 16'h2222, 4'd2},  // R2 address 9
    '{32'hA1F0_0005, 1'b1, 4'd4, 16'h2222, 4'd2},  // R2 nothing staged
    '{32'h0600_0004, 1'b1, 4'd2, 16'h2222, 4'd8},  // R8 mask ch2
    '{32'hA025_5555, 1'b1, 4'd2, 16'h5555, 4'd8},  // R8 bypass
    '{32'hA036_6665, 1'b1, 4'd3, 16'h2222, 4'd8},  // R8 not bypassed
    '{32'h0500_0001, 1'b1, 4'd0, 16'h2222, 4'd9}   // R9 select midscale
  };

  function automatic logic [15:0] chv(input int c);
    return dac_code[c*16 +: 16];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic ld);
    @(negedge clk);
    frame_valid = 1'b1; frame_word = w; load_n = ld;
    @(negedge clk);
    frame_valid = 1'b0; frame_word = 32'h0; load_n = 1'b1;
  endtask

  task automatic pulse_clear(input logic with_frame, input logic [31:0] w);
    @(negedge clk);
    clear_n = 1'b0; frame_valid = with_frame; frame_word = w;
    @(negedge clk);
    clear_n = 1'b1; frame_valid = 1'b0; frame_word = 32'h0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_valid = 1'b0; frame_word = '0; load_n = 1'b1; clear_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state with midscale power-on code
    for (int c = 0; c < 8; c++) chk($sformatf("R10 reset ch%0d", c), chv(c), 16'h8000);
    chk("R10 reset por_flag", por_flag, 1);
    chk("R11 reset ref_on", ref_on, 0);
    chk("R12 reset pd_strobe", pd_strobe, 0);

    foreach (VT[i]) begin
      send(VT[i].w, VT[i].ld);
      chk($sformatf("R%0d vec%0d ch%0d", VT[i].req, i, VT[i].ch), chv(VT[i].ch), VT[i].exp);
    end
    chk("R10 por_flag after writes", por_flag, 0);

    // R9 clear beats a simultaneous frame, clears input registers too
    pulse_clear(1'b1, 32'hA309_9995);
    chk("R9 clear ch0", chv(0), 16'h8000);
    chk("R9 clear ch7", chv(7), 16'h8000);
    send(32'hA1F0_0005, 1'b1);
    chk("R9 input cleared ch3", chv(3), 16'h8000);

    // R9 full-scale selection, then 11 keeps it
    send(32'h0500_0002, 1'b1);
    send(32'h0500_0003, 1'b1);
    send(32'hA310_0015, 1'b1);
    chk("R6 ch1 write", chv(1), 16'h0001);
    pulse_clear(1'b0, 32'h0);
    chk("R9 keep full ch1", chv(1), 16'hFFFF);

    // R11 reference flag
    send(32'h0800_0001, 1'b1);
    chk("R11 ref on", ref_on, 1);

    // R12 power-down hand-off
    @(negedge clk);
    frame_valid = 1'b1; frame_word = 32'h0400_02A5;
    @(negedge clk);
    frame_valid = 1'b0; frame_word = 32'h0;
    chk("R12 pd_strobe", pd_strobe, 1);
    chk("R12 pd_arg", pd_arg, 10'h2A5);
    chk("R12 ch1 unchanged", chv(1), 16'hFFFF);
    @(negedge clk);
    chk("R12 pd_strobe one cycle", pd_strobe, 0);

    // R10 software reset
    send(32'h0700_0000, 1'b1);
    chk("R10 soft ch1", chv(1), 16'h8000);
    chk("R10 soft ref_on", ref_on, 0);
    chk("R10 soft por_flag", por_flag, 1);
    send(32'hA024_3215, 1'b1);
    chk("R10 mask cleared ch2", chv(2), 16'h8000);
    chk("R10 por_flag falls", por_flag, 0);
    pulse_clear(1'b0, 32'h0);
    chk("R10 clear selector zero ch2", chv(2), 16'h0000);

    // R13 reserved command with broadcast address
    send(32'hAFF1_2345, 1'b0);
    chk("R13 reserved ch4", chv(4), 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule